// File: doc/BRIEF.md
# Vector double-to-single round-to-odd narrower

This block narrows a 128-bit vector of two double-precision values into two single-precision values in one clock cycle. Each lane is converted with round-to-odd: the significand is truncated, and its least significant kept bit is forced to 1 whenever any discarded bit is nonzero. A later rounding step can then round the value again without a double-rounding error. Exponent overflow, results below the single-precision normal range, NaNs, infinities and zeros each have a defined result and a defined set of status flags.

The two 32-bit results are packed into a 64-bit pair and merged into a 128-bit destination. In the lower variant the pair fills the low half and the high half is cleared. In the upper variant the pair fills the high half and the low half of the old destination value is kept. The merged vector and the OR of the flags from both lanes are registered, so they appear on the outputs one clock after the inputs are presented.

Top module: `vec_odd_narrow`

## Requirements
- R1: The outputs `dstOut` and `flagsOut` are registered. They reflect the inputs sampled at the previous rising clock edge. While `rstN` is low, both read zero.
- R2: For a result in the single-precision normal range, the 23 result fraction bits are the top 23 source fraction bits. Result bit 0 is forced to 1 when any of the 29 dropped fraction bits is set. In that case inexact is raised. The result exponent field is the source exponent field minus 896.
- R3: The source lane in bits 63:0 produces pair bits 31:0, and the source lane in bits 127:64 produces pair bits 63:32.
- R4: With `upperSel`=0, `dstOut[63:0]` is the pair and `dstOut[127:64]` is zero.
- R5: With `upperSel`=1, `dstOut[127:64]` is the pair and `dstOut[63:0]` equals `oldDst[63:0]`.
- R6: A source exponent field of 1151 or more (and not 2047) gives 0x7F7FFFFF with the source sign. It raises overflow and inexact.
- R7: A result below the single-precision normal range is shifted right to subnormal form, collecting a sticky bit, and then rounded to odd. This includes double subnormals. When the result is inexact, underflow and inexact are both raised; an exact result raises neither.
- R8: A NaN source gives sign, exponent 0xFF, bit 22 set and bits 21:0 taken from source fraction bits 50:29. A signaling NaN (source bit 51 clear) raises invalid.
- R9: Infinities and zeros convert exactly with their sign and raise no flag.
- R10: `flagsOut` is the OR of both lanes' flags, with bit 3 invalid, bit 2 overflow, bit 1 underflow and bit 0 inexact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcVec | input | 128 | Two double-precision source lanes |
| oldDst | input | 128 | Current destination value, low half kept by the upper variant |
| upperSel | input | 1 | 0: lower variant, 1: upper variant |
| dstOut | output | 128 | Merged destination vector |
| flagsOut | output | 4 | Invalid, overflow, underflow, inexact |

## Verification
Each lane is driven from its own class of operands, and the two lanes and the variant are drawn independently:
- Exact normal values are set against values with stray low fraction bits, which separates plain truncation from the forced odd bit.
- Exponents just inside and far beyond the overflow threshold confirm that the result saturates to the largest finite value rather than becoming infinity.
- Operands just below the normal range, deep below it, double subnormals and exactly representable tiny values separate the sticky shift and the underflow rule from truncation.
- Quiet and signaling NaNs, infinities and zeros separate the special cases.
- Differing lanes under both variants show lane order, the cleared high half and the preserved low half.

// File: rtl/narrow_pkg.sv
package narrow_pkg;
  localparam int D_W       = 64;
  localparam int D_EXP_W   = 11;
  localparam int D_FRAC_W  = 52;
  localparam int S_W       = 32;
  localparam int S_EXP_W   = 8;
  localparam int S_FRAC_W  = 23;
  localparam int D_BIAS    = 1023;
  localparam int S_BIAS    = 127;
  localparam int DROP_W    = D_FRAC_W - S_FRAC_W;           // fraction bits lost in range
  localparam int SIG_W     = D_FRAC_W + 1;                  // significand with hidden bit
  localparam int SH_W      = 6;
  localparam int BIAS_GAP  = D_BIAS - S_BIAS;               // 896
  localparam int OVF_EXP   = BIAS_GAP + (1 << S_EXP_W) - 1; // 1151
  localparam int MIN_NORM  = BIAS_GAP + 1;                  // 897
  localparam int SUB_BASE  = BIAS_GAP + DROP_W + 1;         // 926

  typedef enum logic [2:0] {
    CLS_ZERO, CLS_INF, CLS_NAN, CLS_OVF, CLS_NORM, CLS_TINY
  } lane_class_e;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } lane_flags_t;

  typedef struct packed {
    logic writeHigh;  // pair goes to upper half
    logic keepLow;    // lower half taken from old destination
    logic clearHigh;  // upper half forced to zero
  } merge_strobes_t;
endpackage

// File: rtl/sticky_rshift.sv
module sticky_rshift #(
  parameter int IN_W  = 53,
  parameter int OUT_W = 23,
  parameter int SH_W  = 6
) (
  input  logic [IN_W-1:0]  inVal,
  input  logic [SH_W-1:0]  shAmt,
  output logic [OUT_W-1:0] outVal,
  output logic             sticky
);
  logic [IN_W-1:0] lostMask;

  always_comb begin
    // a shift at or beyond IN_W wraps the one-hot to zero, leaving an all-ones mask
    lostMask = (IN_W'(1) << shAmt) - IN_W'(1);
    outVal   = OUT_W'(inVal >> shAmt);
    sticky   = |(inVal & lostMask);
  end
endmodule

// File: rtl/odd_narrow_lane.sv
module odd_narrow_lane
  import narrow_pkg::*;
(
  input  logic [D_W-1:0] dIn,
  output logic [S_W-1:0] sOut,
  output lane_flags_t    flags
);
  logic                sign;
  logic [D_EXP_W-1:0]  dExp;
  logic [D_FRAC_W-1:0] dFrac;
  lane_class_e         cls;
  logic                normSticky;
  logic [D_EXP_W-1:0]  subDist;
  logic [SH_W-1:0]     shSat;
  logic [S_FRAC_W-1:0] tinyMant;
  logic                tinySticky;

  assign sign  = dIn[D_W-1];
  assign dExp  = dIn[D_W-2 -: D_EXP_W];
  assign dFrac = dIn[D_FRAC_W-1:0];

  always_comb begin
    if (&dExp)
      cls = (|dFrac) ? CLS_NAN : CLS_INF;
    else if (dExp == '0 && dFrac == '0)
      cls = CLS_ZERO;
    else if (dExp >= D_EXP_W'(OVF_EXP))
      cls = CLS_OVF;
    else if (dExp >= D_EXP_W'(MIN_NORM))
      cls = CLS_NORM;
    else
      cls = CLS_TINY;
  end

  assign normSticky = |dFrac[DROP_W-1:0];

  // subnormal path: distance from the hidden bit to the result's unit position
  always_comb begin
    subDist = D_EXP_W'(SUB_BASE) - dExp;
    shSat   = (subDist > D_EXP_W'((1 << SH_W) - 1)) ? {SH_W{1'b1}} : subDist[SH_W-1:0];
  end

  sticky_rshift #(
    .IN_W (SIG_W),
    .OUT_W(S_FRAC_W),
    .SH_W (SH_W)
  ) u_tinyShift (
    .inVal ({(dExp != '0), dFrac}),
    .shAmt (shSat),
    .outVal(tinyMant),
    .sticky(tinySticky)
  );

  always_comb begin
    sOut  = '0;
    flags = '0;
    unique case (cls)
      CLS_NAN: begin
        sOut          = {sign, {S_EXP_W{1'b1}}, 1'b1, dFrac[D_FRAC_W-2 -: S_FRAC_W-1]};
        flags.invalid = ~dFrac[D_FRAC_W-1];
      end
      CLS_INF:  sOut = {sign, {S_EXP_W{1'b1}}, {S_FRAC_W{1'b0}}};
      CLS_ZERO: sOut = {sign, {(S_W-1){1'b0}}};
      CLS_OVF: begin
        sOut           = {sign, {(S_EXP_W-1){1'b1}}, 1'b0, {S_FRAC_W{1'b1}}};
        flags.overflow = 1'b1;
        flags.inexact  = 1'b1;
      end
      CLS_NORM: begin
        sOut = {sign, S_EXP_W'(dExp - D_EXP_W'(BIAS_GAP)),
                dFrac[D_FRAC_W-1 -: S_FRAC_W] | {{(S_FRAC_W-1){1'b0}}, normSticky}};
        flags.inexact = normSticky;
      end
      CLS_TINY: begin
        sOut = {sign, {S_EXP_W{1'b0}}, tinyMant | {{(S_FRAC_W-1){1'b0}}, tinySticky}};
        flags.underflow = tinySticky;
        flags.inexact   = tinySticky;
      end
      default: sOut = '0;
    endcase
  end
endmodule

// File: rtl/narrow_ctrl.sv
module narrow_ctrl
  import narrow_pkg::*;
(
  input  logic           upperSel,
  output merge_strobes_t strobes
);
  always_comb begin
    strobes.writeHigh = upperSel;
    strobes.keepLow   = upperSel;
    strobes.clearHigh = ~upperSel;
  end
endmodule

// File: rtl/narrow_datapath.sv
module narrow_datapath
  import narrow_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LANES*D_W-1:0] srcVec,
  input  logic [LANES*D_W-1:0] oldDst,
  input  merge_strobes_t       strobes,
  output logic [LANES*D_W-1:0] dstOut,
  output lane_flags_t          flagsOut
);
  localparam int VEC_W  = LANES * D_W;
  localparam int HALF_W = VEC_W / 2;

  logic [HALF_W-1:0] pair;
  lane_flags_t       laneFlags [LANES];
  lane_flags_t       flagsD;
  logic [HALF_W-1:0] hiPart;
  logic [HALF_W-1:0] loPart;
  logic [VEC_W-1:0]  dstQ;
  lane_flags_t       flagsQ;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    odd_narrow_lane u_lane (
      .dIn  (srcVec[g*D_W +: D_W]),
      .sOut (pair[g*S_W +: S_W]),
      .flags(laneFlags[g])
    );
  end

  always_comb begin
    flagsD = '0;
    for (int i = 0; i < LANES; i++) flagsD = flagsD | laneFlags[i];
  end

  always_comb begin
    loPart = strobes.keepLow ? oldDst[HALF_W-1:0] : pair;
    if (strobes.writeHigh)      hiPart = pair;
    else if (strobes.clearHigh) hiPart = '0;
    else                        hiPart = oldDst[VEC_W-1:HALF_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstQ   <= '0;
      flagsQ <= '0;
    end else begin
      dstQ   <= {hiPart, loPart};
      flagsQ <= flagsD;
    end
  end

  assign dstOut   = dstQ;
  assign flagsOut = flagsQ;

  AST_LOW_VARIANT_CLEARS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearHigh |=> dstQ[VEC_W-1:HALF_W] == '0);  // R4

  AST_UPPER_VARIANT_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.keepLow |=> dstQ[HALF_W-1:0] == $past(oldDst[HALF_W-1:0]));  // R5

  AST_OVERFLOW_IS_INEXACT: assert property (@(posedge clk) disable iff (!rstN)
    flagsQ.overflow |-> flagsQ.inexact);  // R6

  AST_UNDERFLOW_IS_INEXACT: assert property (@(posedge clk) disable iff (!rstN)
    flagsQ.underflow |-> flagsQ.inexact);  // R7

  AST_NAN_STAYS_QUIET_NAN: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.keepLow && (&srcVec[D_W-2 -: D_EXP_W]) && (|srcVec[D_FRAC_W-1:0]))
      |=> dstQ[S_W-2 -: S_EXP_W+1] == '1);  // R8
endmodule

// File: rtl/vec_odd_narrow.sv
module vec_odd_narrow
  import narrow_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LANES*D_W-1:0] srcVec,
  input  logic [LANES*D_W-1:0] oldDst,
  input  logic                 upperSel,
  output logic [LANES*D_W-1:0] dstOut,
  output logic [3:0]           flagsOut
);
  merge_strobes_t strobes;
  lane_flags_t    flagsQ;

  narrow_ctrl u_ctrl (
    .upperSel(upperSel),
    .strobes (strobes)
  );

  narrow_datapath #(.LANES(LANES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .srcVec  (srcVec),
    .oldDst  (oldDst),
    .strobes (strobes),
    .dstOut  (dstOut),
    .flagsOut(flagsQ)
  );

  assign flagsOut = flagsQ;
endmodule

// File: tb/vec_odd_narrow_bench.sv
module vec_odd_narrow_bench;
  logic         clk = 1'b0;
  logic         rstN;
  logic [127:0] srcVec;
  logic [127:0] oldDst;
  logic         upperSel;
  logic [127:0] dstOut;
  logic [3:0]   flagsOut;

  int nCmp = 0;
  int nBad = 0;

  typedef struct {
    logic [127:0] dst;
    logic [3:0]   fl;
    string        tag;
  } exp_t;
  exp_t expQ[$];

  always #5 clk = ~clk;

  vec_odd_narrow u_vec_odd_narrow (
    .clk(clk), .rstN(rstN), .srcVec(srcVec), .oldDst(oldDst),
    .upperSel(upperSel), .dstOut(dstOut), .flagsOut(flagsOut)
  );

  // behavioural model: bit-serial shift, integer exponents; flags {inv,ovf,unf,inx}
  function automatic logic [35:0] refLane(logic [63:0] d);
    logic        s  = d[63];
    int          ex = int'(d[62:52]);
    logic [63:0] m;
    logic [31:0] r;
    logic [3:0]  fl = 4'h0;
    logic        st = 1'b0;
    int          te;
    int          drop;
    if (ex == 2047) begin
      if (d[51:0] == 52'h0) r = {s, 8'hFF, 23'h0};
      else begin
        r = {s, 8'hFF, 1'b1, d[50:29]};
        fl[3] = !d[51];
      end
    end else if (ex == 0 && d[51:0] == 52'h0) begin
      r = {s, 31'h0};
    end else begin
      te = ((ex == 0) ? -1022 : ex - 1023) + 127;
      m  = {11'h0, (ex != 0), d[51:0]};
      if (te >= 255) begin
        r  = {s, 31'h7F7FFFFF};
        fl = 4'b0101;
      end else begin
        drop = (te >= 1) ? 29 : 30 - te;
        if (drop > 60) drop = 60;
        for (int i = 0; i < drop; i++) begin
          st = st | m[0];
          m  = m >> 1;
        end
        r = {s, (te >= 1) ? 8'(te) : 8'h00, m[22:0] | {22'h0, st}};
        fl[0] = st;
        fl[1] = st && (te < 1);
      end
    end
    return {fl, r};
  endfunction

  function automatic string kindTag(int k);
    case (k)
      0, 7:       return "R2";
      1:          return "R6";
      2, 3, 8, 9: return "R7";
      4:          return "R8";
      default:    return "R9";
    endcase
  endfunction

  function automatic logic [63:0] mkLane(int k);
    logic [63:0] rnd = {$urandom(), $urandom()};
    logic [51:0] f   = rnd[51:0];
    logic        s   = rnd[63];
    int          e;
    case (k)
      0: e = 897 + int'($urandom % 254);
      1: e = 1151 + int'($urandom % 896);
      2: e = 860 + int'($urandom % 37);
      3: begin e = 0; f[0] = 1'b1; end
      4: begin e = 2047; f[0] = 1'b1; end
      5: begin e = 2047; f = '0; end
      6: begin e = 0; f = '0; end
      7: begin e = 897 + int'($urandom % 254); f[28:0] = '0; end
      8: begin e = 880 + int'($urandom % 17); f[46:0] = '0; end
      default: e = 1 + int'($urandom % 700);
    endcase
    return {s, 11'(e), f};
  endfunction

  task automatic checkNow();
    exp_t x;
    if (expQ.size() == 0) return;
    x = expQ.pop_front();
    nCmp++;
    if (dstOut !== x.dst) begin
      nBad++;
      $display("FAIL %s R3 dst actual=%h expected=%h", x.tag, dstOut, x.dst);
    end
    nCmp++;
    if (flagsOut !== x.fl) begin
      nBad++;
      $display("FAIL %s R10 flags actual=%b expected=%b", x.tag, flagsOut, x.fl);
    end
  endtask

  task automatic step(logic [127:0] src, logic [127:0] old, logic up, string tag);
    logic [35:0] l0;
    logic [35:0] l1;
    exp_t        x;
    @(negedge clk);
    checkNow();
    srcVec   = src;
    oldDst   = old;
    upperSel = up;
    l0 = refLane(src[63:0]);
    l1 = refLane(src[127:64]);
    x.dst = up ? {l1[31:0], l0[31:0], old[63:0]} : {64'h0, l1[31:0], l0[31:0]};
    x.fl  = l0[35:32] | l1[35:32];
    x.tag = {tag, up ? " R5" : " R4"};
    expQ.push_back(x);
  endtask

  initial begin
    #2_000_000;
    nCmp++;
    nBad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    int k0;
    int k1;
    rstN = 1'b0; srcVec = '0; oldDst = '0; upperSel = 1'b0;
    repeat (3) @(negedge clk);
    srcVec = {2{64'h3FF0000000000001}}; oldDst = '1; upperSel = 1'b1;
    @(negedge clk);
    nCmp++;
    if (dstOut !== 128'h0) begin
      nBad++; $display("FAIL R1 reset dst actual=%h expected=0", dstOut);
    end
    nCmp++;
    if (flagsOut !== 4'h0) begin
      nBad++; $display("FAIL R1 reset flags actual=%b expected=0", flagsOut);
    end
    rstN = 1'b1;
    // directed corners
    step({64'h3FF0000000000000, 64'hBFF0000000000001}, '1, 1'b0, "R2 exact/odd");
    step({64'h47EFFFFFE0000000, 64'h7E37E43C8800759C}, '1, 1'b1, "R6 max/overflow");
    step({64'h7FF0000000000001, 64'h7FF8000000000000}, 128'h1234, 1'b0, "R8 snan/qnan");
    step({64'h3730000000000000, 64'h8000000000000001}, '0, 1'b1, "R7 exact tiny/denorm");
    step({64'hFFF0000000000000, 64'h8000000000000000}, '1, 1'b0, "R9 inf/zero");
    step({64'h0000000000000001, 64'h3810000000000000}, '1, 1'b0, "R7 min/edge");
    step({64'h4000000000000000, 64'hC010000000000000}, '0, 1'b1, "R3 lane order");
    for (int n = 0; n < 3000; n++) begin
      k0 = int'($urandom % 10);
      k1 = int'($urandom % 10);
      step({mkLane(k1), mkLane(k0)}, {$urandom(), $urandom(), $urandom(), $urandom()},
           1'($urandom % 2), {kindTag(k0), "/", kindTag(k1)});
    end
    @(negedge clk);
    checkNow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule